// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Front End

This block is the digital side of an 8-bit voltage-output converter with a parallel host bus. A host writes a byte using active-low chip-select and write strobes. The byte goes into a holding register. It moves on to the converter register either at the end of the write itself or later, when a separate active-low load strobe falls. The level of that load strobe at the moment the write ends picks between the two behaviours. The converter register drives the code that the analog stage turns into a voltage. The code is straight binary, and a value N stands for N/256 of twice the reference.

All host pins are asynchronous to the fast system clock. Each one passes through a synchronizer before any edge is detected. An active-low clear pin forces the converter code to zero at once, with no clock edge needed, and its release is timed to the clock. An active-low power-down pin raises an indication, and while it is asserted every register keeps its contents. After power-on reset the holding register is zero and the converter register follows it, so the output stays at zero until the first completed write. The block also flags a load that is still pending and a host that starts a write while the load strobe is held low after a deferred load.

Top module: `pdac_frontend`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first completed write, `code` is 0x00. `upd_pend` and `proto_err` are 0.
- R2: A write is the interval where `cs_n` and `wr_n` are both low. It ends at the first rise of either strobe. At that point the last bus value seen during the interval is taken into the holding register. Bit 7 of `din` is the MSB, and `code` reproduces `din` bit for bit.
- R3: If `ldac_n` is low when a write ends, `code` takes the written value within 4 clock cycles of the end of the write, and `upd_pend` is 0.
- R4: If `ldac_n` is high when a write ends, `code` keeps its old value and `upd_pend` becomes 1.
- R5: A falling edge on `ldac_n` copies the holding register into `code` and clears `upd_pend`. Whenever `code` changes with `clr_n` high, `upd_pend` is 0.
- R6: While `clr_n` is low, `code` is 0x00 with no clock edge needed, and `upd_pend` is 0. The clear takes priority over any load. The holding register keeps its value, so a later `ldac_n` fall restores it to `code`.
- R7: While `pd_n` is low, `pd_ind` is 1. Writes and `ldac_n` edges change neither register. After `pd_n` returns high, `pd_ind` is 0.
- R8: If a write begins while `ldac_n` is still low after a load that took a pending value, `proto_err` becomes 1. It stays 1 until reset.
- R9: A strobe on only one of `cs_n` or `wr_n`, with the other high, changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ldac_n | input | 1 | Load strobe for the converter register, active low |
| clr_n | input | 1 | Asynchronous clear of the converter code, active low |
| pd_n | input | 1 | Power-down request, active low |
| din | input | 8 | Parallel data bus, bit 7 is the MSB |
| code | output | 8 | Code driven to the converter |
| pd_ind | output | 1 | Power-down indication |
| upd_pend | output | 1 | A written value is waiting for a load strobe |
| proto_err | output | 1 | Sticky flag: a write started while the load strobe was still low |

## Verification
Two situations are hard to reach from the pins. The first is proving that power-down and clear leave the holding register untouched. The holding register is not a port, so the stimulus first writes a value without loading it, then clears or powers down, attempts a write, and afterwards drops the load strobe; the value that then appears on `code` shows what the holding register contained. The second is the protocol-error case. It needs a deferred write, then a load strobe that stays low, then a new write started before the strobe is raised again; a dedicated directed sequence builds exactly that order.

// File: rtl/pdac_pkg.sv
// Shared constants and types for the parallel DAC front end.
package pdac_pkg;
    localparam int CODE_W = 8;
    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/pdac_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is sampled on its own; the reset value is applied synchronously.
module pdac_sync #(
    parameter int W       = 1,
    parameter int STAGES  = 2,
    parameter logic RST_V = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            // Shift the input one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= {W{RST_V}};
                else        stg[i] <= (i == 0) ? d : stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pdac_clr_ctl.sv
// Clear conditioner: asserts at once when clr_n falls, with no clock needed,
// and releases only after CLR_STAGES rising clock edges with clr_n high.
module pdac_clr_ctl #(
    parameter int CLR_STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic clr_act
);
    logic [CLR_STAGES-1:0] sh;

    // Set on the asynchronous assert; shift zeros in to release.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) sh <= '1;
        else        sh <= {sh[CLR_STAGES-2:0], 1'b0};
    end

    assign clr_act = sh[CLR_STAGES-1];
endmodule

// File: rtl/pdac_core.sv
// Register core: holding register, converter register and status flags.
// Assumes all strobes are already synchronized (active low) and the data
// is delayed by the same number of stages as the strobes.
module pdac_core
    import pdac_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_act,
    input  logic  cs_s,
    input  logic  wr_s,
    input  logic  ldac_s,
    input  logic  pd_s,
    input  code_t din_s,
    output code_t code,
    output logic  upd_pend,
    output logic  proto_err,
    output logic  pd_ind
);
    logic  wr_act, wr_act_q, ldac_q;
    logic  wr_end, wr_start, ldac_fall, ldac_rise;
    logic  por, sync_loaded;
    code_t din_hold, hold_reg, dac_reg;

    assign wr_act    = !cs_s && !wr_s;
    assign wr_end    = wr_act_q && !wr_act;
    assign wr_start  = !wr_act_q && wr_act;
    assign ldac_fall = ldac_q && !ldac_s;
    assign ldac_rise = !ldac_q && ldac_s;

    // Remember the previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            ldac_q   <= 1'b1;
        end else begin
            wr_act_q <= wr_act;
            ldac_q   <= ldac_s;
        end
    end

    // Track the bus value during the write so the last one is kept at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)      din_hold <= '0;
        else if (wr_act) din_hold <= din_s;
    end

    // Holding register and power-on transparency flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_reg <= '0;
            por      <= 1'b1;
        end else if (pd_s && wr_end) begin
            hold_reg <= din_hold;
            por      <= 1'b0;
        end
    end

    // Converter register and pending flag; the clear overrides every load.
    always_ff @(posedge clk or posedge clr_act) begin
        if (clr_act) begin
            dac_reg  <= '0;
            upd_pend <= 1'b0;
        end else if (!rst_n) begin
            dac_reg  <= '0;
            upd_pend <= 1'b0;
        end else if (pd_s) begin
            if (wr_end) begin
                if (!ldac_s) begin
                    dac_reg  <= din_hold;
                    upd_pend <= 1'b0;
                end else begin
                    upd_pend <= 1'b1;
                end
            end else if (ldac_fall) begin
                dac_reg  <= hold_reg;
                upd_pend <= 1'b0;
            end else if (por) begin
                dac_reg  <= hold_reg;
            end
        end
    end

    // Detect a write started while the load strobe is still low after a deferred load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_loaded <= 1'b0;
            proto_err   <= 1'b0;
        end else begin
            if (pd_s && ldac_fall && upd_pend) sync_loaded <= 1'b1;
            else if (ldac_rise)                sync_loaded <= 1'b0;
            if (wr_start && sync_loaded && !ldac_s) proto_err <= 1'b1;
        end
    end

    assign code   = dac_reg;
    assign pd_ind = !pd_s;
endmodule

// File: rtl/pdac_frontend.sv
// Top level of the parallel DAC front end. It synchronizes the host pins,
// conditions the clear and instantiates the register core.
// Assumes clk is much faster than the host strobes.
module pdac_frontend #(
    parameter int DATA_W      = pdac_pkg::CODE_W,
    parameter int SYNC_STAGES = 2,
    parameter int CLR_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ldac_n,
    input  logic              clr_n,
    input  logic              pd_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] code,
    output logic              pd_ind,
    output logic              upd_pend,
    output logic              proto_err
);
    localparam int NCTL = 4;

    logic [NCTL-1:0]   ctl_s;
    pdac_pkg::code_t   din_s;
    logic              clr_act;

    pdac_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, wr_n, ldac_n, pd_n}), .q(ctl_s)
    );

    pdac_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_V(1'b0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
    );

    pdac_clr_ctl #(.CLR_STAGES(CLR_STAGES)) u_clr (
        .clk(clk), .clr_n(clr_n), .clr_act(clr_act)
    );

    pdac_core u_core (
        .clk(clk), .rst_n(rst_n), .clr_act(clr_act),
        .cs_s(ctl_s[3]), .wr_s(ctl_s[2]), .ldac_s(ctl_s[1]), .pd_s(ctl_s[0]),
        .din_s(din_s), .code(code), .upd_pend(upd_pend),
        .proto_err(proto_err), .pd_ind(pd_ind)
    );
endmodule

// File: rtl/pdac_frontend_chk.sv
// Checker for the DAC front end; attached to every instance of the top level.
module pdac_frontend_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wr_n,
    input logic       ldac_n,
    input logic       clr_n,
    input logic       pd_n,
    input logic [7:0] din,
    input logic [7:0] code,
    input logic       pd_ind,
    input logic       upd_pend,
    input logic       proto_err
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (code == 8'h00 && !upd_pend && !proto_err));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (code == 8'h00 && !upd_pend));

    // R4
    defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_pend) |-> $stable(code));

    // R5
    load_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code) && clr_n && $past(clr_n)) |-> !upd_pend);

    // R7
    pd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_n && $past(!pd_n) && $past(!pd_n, 2)) |=> ($stable(code) || !clr_n));

    // R7
    pd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_n && $past(!pd_n) && $past(!pd_n, 2)) |-> pd_ind);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(proto_err) |-> proto_err);
endmodule

bind pdac_frontend pdac_frontend_chk u_chk (.*);

// File: tb/sim_pdac_frontend.sv
module sim_pdac_frontend;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1, pd_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] code;
    logic       pd_ind, upd_pend, proto_err;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_code = 8'h00;

    always #2.5 clk = ~clk;

    pdac_frontend u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ldac_n(ldac_n),
        .clr_n(clr_n), .pd_n(pd_n), .din(din), .code(code), .pd_ind(pd_ind),
        .upd_pend(upd_pend), .proto_err(proto_err)
    );

    // Vector: {ldac level at write end, end by cs, data}
    localparam logic [9:0] VEC [0:5] = '{
        {1'b0, 1'b0, 8'hA5}, {1'b1, 1'b0, 8'h3C}, {1'b0, 1'b1, 8'hFF},
        {1'b1, 1'b1, 8'h81}, {1'b0, 1'b0, 8'h00}, {1'b1, 1'b0, 8'h7E}
    };

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d, input logic ld, input logic by_cs);
        ldac_n = ld; din = d;
        waitc(3);
        cs_n = 1'b0; waitc(2);
        wr_n = 1'b0; waitc(3);
        if (by_cs) begin cs_n = 1'b1; waitc(2); wr_n = 1'b1; end
        else       begin wr_n = 1'b1; waitc(2); cs_n = 1'b1; end
        waitc(5);
    endtask

    task automatic ldac_pulse();
        ldac_n = 1'b1; waitc(4);
        ldac_n = 1'b0; waitc(5);
        ldac_n = 1'b1; waitc(4);
    endtask

    initial begin
        #500000;
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        waitc(4);
        chk("R1 code in reset", code, 8'h00);
        chk("R1 pend in reset", {7'd0, upd_pend}, 8'h00);
        rst_n = 1'b1;
        waitc(6);
        chk("R1 code after reset", code, 8'h00);
        chk("R1 err after reset", {7'd0, proto_err}, 8'h00);

        // Table walk over R2, R3, R4, R5
        for (int i = 0; i < 6; i++) begin
            logic ld; logic [7:0] d;
            ld = VEC[i][9]; d = VEC[i][7:0];
            do_write(d, ld, VEC[i][8]);
            if (!ld) exp_code = d;
            chk(ld ? "R4 code held" : "R2 R3 code loaded", code, exp_code);
            chk(ld ? "R4 pend set" : "R3 pend clear", {7'd0, upd_pend}, {7'd0, ld});
            if (ld) begin
                ldac_pulse();
                exp_code = d;
                chk("R5 code after load", code, exp_code);
                chk("R5 pend cleared", {7'd0, upd_pend}, 8'h00);
            end
            chk("R2 no protocol error", {7'd0, proto_err}, 8'h00);
        end

        // R9: single strobes do nothing
        ldac_n = 1'b0; din = 8'h77; waitc(3);
        wr_n = 1'b0; waitc(4); wr_n = 1'b1; waitc(3);
        cs_n = 1'b0; waitc(4); cs_n = 1'b1; waitc(5);
        chk("R9 code unchanged", code, exp_code);
        ldac_pulse();
        chk("R9 holding reg unchanged", code, exp_code);

        // R6: clear is immediate and keeps the holding register
        do_write(8'h5A, 1'b0, 1'b0);
        do_write(8'hC3, 1'b1, 1'b0);
        chk("R4 deferred", code, 8'h5A);
        #1 clr_n = 1'b0;
        #0.5;
        chk("R6 code zero at once", code, 8'h00);
        chk("R6 pend cleared", {7'd0, upd_pend}, 8'h00);
        waitc(3);
        clr_n = 1'b1; waitc(5);
        chk("R6 code zero after release", code, 8'h00);
        ldac_pulse();
        chk("R6 holding reg kept", code, 8'hC3);

        // R7: power-down freezes both registers
        pd_n = 1'b0; waitc(4);
        chk("R7 pd_ind set", {7'd0, pd_ind}, 8'h01);
        do_write(8'h11, 1'b0, 1'b0);
        chk("R7 write ignored", code, 8'hC3);
        ldac_pulse();
        chk("R7 ldac ignored", code, 8'hC3);
        pd_n = 1'b1; waitc(4);
        chk("R7 pd_ind clear", {7'd0, pd_ind}, 8'h00);
        ldac_pulse();
        chk("R7 holding reg untouched", code, 8'hC3);

        // R8: write started with ldac still low after a deferred load
        do_write(8'h42, 1'b1, 1'b0);
        ldac_n = 1'b0; waitc(5);
        chk("R5 deferred load", code, 8'h42);
        chk("R8 no error yet", {7'd0, proto_err}, 8'h00);
        do_write(8'h24, 1'b0, 1'b0);
        chk("R8 error raised", {7'd0, proto_err}, 8'h01);
        ldac_n = 1'b1; waitc(4);
        do_write(8'h66, 1'b1, 1'b0);
        chk("R8 error sticky", {7'd0, proto_err}, 8'h01);
        rst_n = 1'b0; waitc(3); rst_n = 1'b1; waitc(4);
        chk("R8 error cleared by reset", {7'd0, proto_err}, 8'h00);
        chk("R1 code after second reset", code, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule